// File: doc/BRIEF.md
# Virtually Indexed Write-Through Data Cache

This block is a direct-mapped cache of 32-bit words that sits between an address-translation stage and a word-wide synchronous main memory. The cache is indexed by the virtual word address. Each line holds eight consecutive words. Each line carries a tag made of upper virtual address bits, a valid flag and the context number that was current when the line was filled. A read that hits is answered from the data array. A cacheable read that misses loads the whole line from the line-aligned physical address, using a fill sequencer that issues eight memory reads in ascending order. Reads and writes to pages the translation stage marks uncached go straight to memory.

Every write to memory goes through at once. A write that hits also updates the cached word, and a write that misses on a valid line invalidates that line. For maintenance, a single request port also carries diagnostic reads and writes of the tag and data arrays, and a flush command that invalidates the indexed line only when its stored context equals the current one. The port accepts one request when `ready` is high and answers every request with a one-cycle `respValid` pulse.

Top module: `vwt_dcache`

## Requirements
- R1: After reset every tag entry reads as zero, so every line is invalid. `ready` is high and `respValid` is low.
- R2: A cacheable read (op 0) whose indexed tag has bit 19 set and tag bits 15:2 equal to word-address bits 27:14 returns the addressed word with no memory access. `respValid` rises in the cycle after acceptance.
- R3: A cacheable read miss writes the tag as valid bit 19, the current context from bit 20 upward, and word-address bits 27:14 in bits 15:2. It then performs eight memory reads of the line-aligned physical address, in ascending order. `ready` stays low during the fill, and the requested word is returned only after the last beat.
- R4: The hit decision does not depend on the current context: a valid matching line hits under any context value.
- R5: A read marked uncached performs exactly one memory read of the given physical address, returns that word and leaves the tag array unchanged.
- R6: Every write (op 1) updates memory with its byte enables. A cacheable write that hits also merges the same bytes into the cached word.
- R7: A cacheable write whose line is valid but whose tag mismatches clears that line's valid bit. A write to an invalid line leaves that line's tag and data unchanged.
- R8: An uncached write updates memory only; cache tags and data are unchanged.
- R9: Diagnostic tag read (op 2) and tag write (op 3) address the line selected by address bits [INDEX_W+2:3]. A tag write stores the write data ANDed with 0x03F8FFFC.
- R10: Diagnostic data read (op 4) and data write (op 5) address the word selected by address bits [INDEX_W+2:0]. A data write merges bytes under the byte enables and clears the valid bit of that word's line.
- R11: A context flush (op 6) clears the indexed line's valid bit only if the line is valid and its stored context equals `curCtx`. Otherwise the tag is unchanged.
- R12: Each accepted request produces exactly one `respValid` pulse lasting one cycle. A memory write is issued in the cycle after a write is accepted, and its response follows the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqOp | input | 3 | Operation code (0 read, 1 write, 2 tag read, 3 tag write, 4 data read, 5 data write, 6 context flush) |
| reqAddr | input | VA_W | Virtual word address |
| reqPaddr | input | PA_W | Physical word address from translation |
| reqUncached | input | 1 | Page is not cacheable |
| reqByteEn | input | 4 | Byte enables for writes |
| reqWdata | input | 32 | Write data |
| curCtx | input | CTX_W | Current context number |
| ready | output | 1 | Request port can accept |
| respValid | output | 1 | Response pulse |
| respRdata | output | 32 | Read or diagnostic result |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | PA_W | Memory word address |
| memBe | output | 4 | Memory byte enables |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid the cycle after memRe |

## Verification
The bench builds the cache with INDEX_W=3, PA_W=10, VA_W=28 and CTX_W=3. This gives eight lines, so the sweep can fill every line under its own context, return every word offset as the requested word, and read back all 64 cached words as hits under a different context. The 1024-word physical space lets a bench-side memory model hold reference contents that are computed arithmetically and count every memory beat. The full tag field at bits 27:14 and all eight context values are reachable, so the bench can exercise mismatching-tag writes and context flushes that both match and do not match.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_TAG_RD    = 3'd2,
    OP_TAG_WR    = 3'd3,
    OP_DATA_RD   = 3'd4,
    OP_DATA_WR   = 3'd5,
    OP_CTX_FLUSH = 3'd6
  } cacheOp_e;

  localparam int          VALID_BIT     = 19;
  localparam int          CTX_LSB       = 20;
  localparam logic [31:0] TAG_KEEP_MASK = 32'h03F8_FFFC;

  typedef struct packed {
    logic       capture;
    logic       tagFill;
    logic       tagDiagWr;
    logic       tagInval;
    logic       wordWr;
    logic       loadTag;
    logic       loadData;
    logic       fillWr;
    logic       exactAddr;
    logic       rcvValid;
    logic [2:0] issueIdx;
    logic [2:0] rcvIdx;
  } strobes_t;

  function automatic logic [31:0] byteMerge(input logic [31:0] oldW,
                                            input logic [31:0] newW,
                                            input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[b*8 +: 8] = be[b] ? newW[b*8 +: 8] : oldW[b*8 +: 8];
    return r;
  endfunction

endpackage

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       reqUncached,
  input  logic       hit,
  input  logic       lineValid,
  input  logic       ctxMatch,
  output strobes_t   strb,
  output logic       ready,
  output logic       respValid,
  output logic       memRe,
  output logic       memWe
);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_WRMEM} state_e;

  state_e     state;
  logic [3:0] issueCnt;
  logic       rcvValid;
  logic [2:0] rcvIdx;
  logic       uncReg;
  logic       accept;
  logic [3:0] beats;
  logic       lastRcv;
  cacheOp_e   op;

  assign op      = cacheOp_e'(reqOp);
  assign ready   = (state == ST_IDLE);
  assign accept  = reqValid && ready;
  assign beats   = uncReg ? 4'd1 : 4'd8;
  assign memRe   = (state == ST_FILL) && (issueCnt < beats);
  assign memWe   = (state == ST_WRMEM);
  assign lastRcv = rcvValid && ({1'b0, rcvIdx} == beats - 4'd1);

  always_comb begin
    strb           = '0;
    strb.capture   = accept;
    strb.issueIdx  = issueCnt[2:0];
    strb.rcvIdx    = rcvIdx;
    strb.rcvValid  = rcvValid;
    strb.fillWr    = rcvValid && !uncReg;
    strb.exactAddr = uncReg || (state == ST_WRMEM);
    if (accept) begin
      unique case (op)
        OP_READ: begin
          if (!reqUncached && hit) strb.loadData = 1'b1;
          else if (!reqUncached)   strb.tagFill  = 1'b1;
        end
        OP_WRITE: begin
          if (!reqUncached && hit)            strb.wordWr   = 1'b1;
          else if (!reqUncached && lineValid) strb.tagInval = 1'b1;
        end
        OP_TAG_RD:  strb.loadTag   = 1'b1;
        OP_TAG_WR:  strb.tagDiagWr = 1'b1;
        OP_DATA_RD: strb.loadData  = 1'b1;
        OP_DATA_WR: begin
          strb.wordWr   = 1'b1;
          strb.tagInval = 1'b1;
        end
        OP_CTX_FLUSH: strb.tagInval = lineValid && ctxMatch;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      issueCnt  <= '0;
      rcvValid  <= 1'b0;
      rcvIdx    <= '0;
      uncReg    <= 1'b0;
      respValid <= 1'b0;
    end else begin
      respValid <= 1'b0;
      rcvValid  <= memRe;
      rcvIdx    <= issueCnt[2:0];
      unique case (state)
        ST_IDLE: if (accept) begin
          if (op == OP_READ && (reqUncached || !hit)) begin
            state    <= ST_FILL;
            issueCnt <= '0;
            uncReg   <= reqUncached;
          end else if (op == OP_WRITE) begin
            state <= ST_WRMEM;
          end else begin
            respValid <= 1'b1;
          end
        end
        ST_FILL: begin
          if (memRe) issueCnt <= issueCnt + 4'd1;
          if (lastRcv) begin
            state     <= ST_IDLE;
            respValid <= 1'b1;
            uncReg    <= 1'b0;
          end
        end
        ST_WRMEM: begin
          state     <= ST_IDLE;
          respValid <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12
  write_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (respValid && ready));

  // R3
  fill_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastRcv && !uncReg) |-> (issueCnt == 4'd8));

  // R3
  busy_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> !ready);

endmodule

// File: rtl/dcache_dp.sv
module dcache_dp
  import dcache_pkg::*;
#(
  parameter int VA_W    = 30,
  parameter int PA_W    = 24,
  parameter int INDEX_W = 6,
  parameter int CTX_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic [PA_W-1:0]   reqPaddr,
  input  logic [3:0]        reqByteEn,
  input  logic [31:0]       reqWdata,
  input  logic [CTX_W-1:0]  curCtx,
  output logic              hit,
  output logic              lineValid,
  output logic              ctxMatch,
  output logic [PA_W-1:0]   memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic [31:0]       respRdata
);

  localparam int LINES  = 1 << INDEX_W;
  localparam int WIDX_W = INDEX_W + 3;
  localparam int WORDS  = LINES * 8;

  logic [31:0] tagMem  [LINES];
  logic [31:0] dataMem [WORDS];

  logic [INDEX_W-1:0] liveIdx;
  logic [WIDX_W-1:0]  liveWord;
  logic [31:0]        liveTag;
  logic [31:0]        fillTag;
  logic [WIDX_W-1:0]  capWord;
  logic [PA_W-1:0]    capPaddr;
  logic [3:0]         capBe;
  logic [31:0]        capWdata;
  logic               grab;

  assign liveIdx   = reqAddr[WIDX_W-1:3];
  assign liveWord  = reqAddr[WIDX_W-1:0];
  assign liveTag   = tagMem[liveIdx];
  assign lineValid = liveTag[VALID_BIT];
  assign hit       = lineValid && (liveTag[15:2] == reqAddr[27:14]);
  assign ctxMatch  = (liveTag[CTX_LSB +: CTX_W] == curCtx);
  assign grab      = strb.rcvValid && (strb.exactAddr || strb.rcvIdx == capWord[2:0]);

  assign memAddr  = strb.exactAddr ? capPaddr : {capPaddr[PA_W-1:3], strb.issueIdx};
  assign memBe    = capBe;
  assign memWdata = capWdata;

  always_comb begin
    fillTag                       = '0;
    fillTag[VALID_BIT]            = 1'b1;
    fillTag[CTX_LSB +: CTX_W]     = curCtx;
    fillTag[15:2]                 = reqAddr[27:14];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) tagMem[i] <= '0;
    end else if (strb.tagFill) begin
      tagMem[liveIdx] <= fillTag;
    end else if (strb.tagDiagWr) begin
      tagMem[liveIdx] <= reqWdata & TAG_KEEP_MASK;
    end else if (strb.tagInval) begin
      tagMem[liveIdx][VALID_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wordWr)
      dataMem[liveWord] <= byteMerge(dataMem[liveWord], reqWdata, reqByteEn);
    else if (strb.fillWr)
      dataMem[{capWord[WIDX_W-1:3], strb.rcvIdx}] <= memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capWord   <= '0;
      capPaddr  <= '0;
      capBe     <= '0;
      capWdata  <= '0;
      respRdata <= '0;
    end else begin
      if (strb.capture) begin
        capWord  <= liveWord;
        capPaddr <= reqPaddr;
        capBe    <= reqByteEn;
        capWdata <= reqWdata;
      end
      if (strb.loadTag)       respRdata <= liveTag;
      else if (strb.loadData) respRdata <= dataMem[liveWord];
      else if (grab)          respRdata <= memRdata;
    end
  end

  // R3
  fill_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tagFill |=> (tagMem[$past(liveIdx)][VALID_BIT] &&
                      tagMem[$past(liveIdx)][15:2] == $past(reqAddr[27:14])));

  // R9
  tag_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tagDiagWr |=> ((tagMem[$past(liveIdx)] & ~TAG_KEEP_MASK) == 32'd0));

  // R7
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tagInval |=> !tagMem[$past(liveIdx)][VALID_BIT]);

  // R10
  no_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillWr |-> (!strb.wordWr && !strb.capture));

endmodule

// File: rtl/vwt_dcache.sv
module vwt_dcache
  import dcache_pkg::*;
#(
  parameter int VA_W    = 30,
  parameter int PA_W    = 24,
  parameter int INDEX_W = 6,
  parameter int CTX_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic [PA_W-1:0]  reqPaddr,
  input  logic             reqUncached,
  input  logic [3:0]       reqByteEn,
  input  logic [31:0]      reqWdata,
  input  logic [CTX_W-1:0] curCtx,
  output logic             ready,
  output logic             respValid,
  output logic [31:0]      respRdata,
  output logic             memRe,
  output logic             memWe,
  output logic [PA_W-1:0]  memAddr,
  output logic [3:0]       memBe,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata
);

  strobes_t strb;
  logic     hit;
  logic     lineValid;
  logic     ctxMatch;

  dcache_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqOp       (reqOp),
    .reqUncached (reqUncached),
    .hit         (hit),
    .lineValid   (lineValid),
    .ctxMatch    (ctxMatch),
    .strb        (strb),
    .ready       (ready),
    .respValid   (respValid),
    .memRe       (memRe),
    .memWe       (memWe)
  );

  dcache_dp #(
    .VA_W    (VA_W),
    .PA_W    (PA_W),
    .INDEX_W (INDEX_W),
    .CTX_W   (CTX_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqPaddr  (reqPaddr),
    .reqByteEn (reqByteEn),
    .reqWdata  (reqWdata),
    .curCtx    (curCtx),
    .hit       (hit),
    .lineValid (lineValid),
    .ctxMatch  (ctxMatch),
    .memAddr   (memAddr),
    .memBe     (memBe),
    .memWdata  (memWdata),
    .memRdata  (memRdata),
    .respRdata (respRdata)
  );

endmodule

// File: tb/vwt_dcache_tb_top.sv
module vwt_dcache_tb_top;

  localparam int VA_W    = 28;
  localparam int PA_W    = 10;
  localparam int INDEX_W = 3;
  localparam int CTX_W   = 3;
  localparam int MEM_N   = 1 << PA_W;
  localparam logic [31:0] VBIT = 32'h0008_0000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [2:0]       reqOp = '0;
  logic [VA_W-1:0]  reqAddr = '0;
  logic [PA_W-1:0]  reqPaddr = '0;
  logic             reqUncached = 1'b0;
  logic [3:0]       reqByteEn = '0;
  logic [31:0]      reqWdata = '0;
  logic [CTX_W-1:0] curCtx = '0;
  logic             ready;
  logic             respValid;
  logic [31:0]      respRdata;
  logic             memRe;
  logic             memWe;
  logic [PA_W-1:0]  memAddr;
  logic [3:0]       memBe;
  logic [31:0]      memWdata;
  logic [31:0]      memRdata = '0;

  logic [31:0] mem    [MEM_N];
  logic [31:0] expMem [MEM_N];
  int memReads = 0;
  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  vwt_dcache #(.VA_W(VA_W), .PA_W(PA_W), .INDEX_W(INDEX_W), .CTX_W(CTX_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqPaddr(reqPaddr), .reqUncached(reqUncached), .reqByteEn(reqByteEn),
    .reqWdata(reqWdata), .curCtx(curCtx), .ready(ready), .respValid(respValid),
    .respRdata(respRdata), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] initWord(input int a);
    return 32'(a) * 32'h0100_0193 + 32'hC0DE_0000;
  endfunction

  function automatic logic [VA_W-1:0] va(input int line, input int off, input int tagv);
    return VA_W'((tagv << 14) | (line << 3) | off);
  endfunction

  function automatic logic [PA_W-1:0] pa(input int line, input int off);
    return PA_W'((16 + 3 * line) * 8 + off);
  endfunction

  function automatic logic [31:0] tagOf(input int line);
    return VBIT | (32'(line) << 20) | (32'(16'h1A5 + line) << 2);
  endfunction

  always @(posedge clk) begin
    if (memRe) begin
      memRdata <= mem[memAddr];
      memReads <= memReads + 1;
    end
    if (memWe) mem[memAddr] <= merge(mem[memAddr], memWdata, memBe);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic [VA_W-1:0] a, input logic [PA_W-1:0] p,
                      input logic unc, input logic [3:0] be, input logic [31:0] wd,
                      input int ctx, output logic [31:0] rd);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqPaddr = p; reqUncached = unc;
    reqByteEn = be; reqWdata = wd; curCtx = CTX_W'(ctx);
    while (!ready) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    while (!respValid) @(negedge clk);
    rd = respRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int r0;
    logic [31:0] w;
    for (int a = 0; a < MEM_N; a++) begin
      mem[a] = initWord(a);
      expMem[a] = initWord(a);
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(ready), 32'd1);
    chk("R1 respValid", 32'(respValid), 32'd0);
    for (int l = 0; l < 8; l++) begin
      doOp(3'd2, va(l, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
      chk("R1 tag after reset", rd, 32'd0);
    end

    // R3 fill every line, R2/R4 hit every word under another context
    for (int l = 0; l < 8; l++) begin
      r0 = memReads;
      doOp(3'd0, va(l, l, 16'h1A5 + l), pa(l, l), 1'b0, 4'h0, '0, l, rd);
      chk("R3 miss word", rd, expMem[pa(l, l)]);
      chk("R3 fill beats", 32'(memReads - r0), 32'd8);
      doOp(3'd2, va(l, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
      chk("R3 fill tag", rd, tagOf(l));
      for (int o = 0; o < 8; o++) begin
        r0 = memReads;
        doOp(3'd0, va(l, o, 16'h1A5 + l), '0, 1'b0, 4'h0, '0, (l + 1) % 8, rd);
        chk("R2 R4 hit data", rd, expMem[pa(l, o)]);
        chk("R2 no mem access", 32'(memReads - r0), 32'd0);
      end
    end
    // R12 single pulse
    @(negedge clk);
    chk("R12 pulse width", 32'(respValid), 32'd0);

    // R10 diagnostic data read of filled word
    doOp(3'd4, va(6, 3, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R10 data read", rd, expMem[pa(6, 3)]);

    // R6 write hit, byte enables
    doOp(3'd1, va(0, 2, 16'h1A5), pa(0, 2), 1'b0, 4'b0101, 32'hA1B2C3D4, 0, rd);
    expMem[pa(0, 2)] = merge(expMem[pa(0, 2)], 32'hA1B2C3D4, 4'b0101);
    chk("R6 memory merged", mem[pa(0, 2)], expMem[pa(0, 2)]);
    r0 = memReads;
    doOp(3'd0, va(0, 2, 16'h1A5), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R6 cache merged", rd, expMem[pa(0, 2)]);
    chk("R6 still hits", 32'(memReads - r0), 32'd0);

    // R7 write miss on valid line invalidates
    doOp(3'd1, va(1, 4, 16'h2000), 10'd900, 1'b0, 4'hF, 32'h5555AAAA, 1, rd);
    expMem[900] = 32'h5555AAAA;
    chk("R6 miss writes memory", mem[900], expMem[900]);
    doOp(3'd2, va(1, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R7 line invalidated", rd, tagOf(1) & ~VBIT);
    // R7 write to invalid line leaves tag and data
    doOp(3'd1, va(1, 0, 16'h1A6), pa(1, 0), 1'b0, 4'hF, 32'h0BADF00D, 1, rd);
    expMem[pa(1, 0)] = 32'h0BADF00D;
    doOp(3'd2, va(1, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R7 invalid tag kept", rd, tagOf(1) & ~VBIT);
    doOp(3'd4, va(1, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R7 invalid data kept", rd, initWord(int'(pa(1, 0))));
    chk("R6 memory on invalid line", mem[pa(1, 0)], expMem[pa(1, 0)]);

    // R8 uncached write
    doOp(3'd1, va(2, 3, 16'h1A7), pa(2, 3), 1'b1, 4'hF, 32'h13572468, 2, rd);
    expMem[pa(2, 3)] = 32'h13572468;
    chk("R8 memory written", mem[pa(2, 3)], expMem[pa(2, 3)]);
    doOp(3'd4, va(2, 3, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R8 cache data kept", rd, initWord(int'(pa(2, 3))));
    doOp(3'd2, va(2, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R8 tag kept", rd, tagOf(2));

    // R5 uncached read
    r0 = memReads;
    doOp(3'd0, va(3, 1, 16'h1A8), 10'd700, 1'b1, 4'h0, '0, 3, rd);
    chk("R5 uncached data", rd, expMem[700]);
    chk("R5 one beat", 32'(memReads - r0), 32'd1);
    doOp(3'd2, va(3, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R5 tag kept", rd, tagOf(3));

    // R9 tag write mask
    doOp(3'd3, va(6, 0, 0), '0, 1'b0, 4'h0, 32'hFFFFFFFF, 0, rd);
    doOp(3'd2, va(6, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R9 masked tag", rd, 32'h03F8FFFC);

    // R10 data write merges and invalidates
    w = merge(expMem[pa(4, 5)], 32'h12345678, 4'b1100);
    doOp(3'd5, va(4, 5, 0), '0, 1'b0, 4'b1100, 32'h12345678, 0, rd);
    doOp(3'd4, va(4, 5, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R10 data merged", rd, w);
    doOp(3'd2, va(4, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R10 line invalidated", rd, tagOf(4) & ~VBIT);

    // R11 context flush
    doOp(3'd6, va(5, 0, 0), '0, 1'b0, 4'h0, '0, 2, rd);
    doOp(3'd2, va(5, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R11 other context kept", rd, tagOf(5));
    doOp(3'd6, va(5, 0, 0), '0, 1'b0, 4'h0, '0, 5, rd);
    doOp(3'd2, va(5, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R11 matching context cleared", rd, tagOf(5) & ~VBIT);
    r0 = memReads;
    doOp(3'd0, va(5, 0, 16'h1AA), pa(5, 0), 1'b0, 4'h0, '0, 5, rd);
    chk("R11 flushed line misses", 32'(memReads - r0), 32'd8);

    // R3 refill of invalidated line returns memory contents
    r0 = memReads;
    doOp(3'd0, va(1, 4, 16'h1A6), pa(1, 4), 1'b0, 4'h0, '0, 1, rd);
    chk("R3 refill word", rd, expMem[pa(1, 4)]);
    chk("R3 refill beats", 32'(memReads - r0), 32'd8);
    doOp(3'd4, va(1, 0, 0), '0, 1'b0, 4'h0, '0, 0, rd);
    chk("R3 refill line word0", rd, expMem[pa(1, 0)]);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule